// File: doc/BRIEF.md
# Protected CAN Mode Control Register

This block is the host-side mode and control register of a CAN protocol controller. Software writes it over a simple register bus and reads it back. Some mode bits can only be armed while the controller is held in initialization with configuration change unlocked. Clears of those bits are always honoured. A few bits are written with no condition at all.

The initialization flag is carried into the CAN core clock domain through a synchronizer. Software sees the value that the core has acknowledged, so a change shows on readback only after a short lag. A busy flag stays high while the two domains disagree.

The block also runs a clock-stop handshake. Once stop is requested and the bus is quiet, the block forces initialization. When the core has accepted that, it raises an acknowledge that tells the system the CAN clocks may be gated.

Top module: `can_ctrl_reg`

## Requirements
- R1: After reset the readback is 0x00000001. Bits 31:15 and 11:10 always read 0, and writing 1 to them has no effect.
- R2: The bits FD enable (8), rate switch enable (9), exception handling off (12), edge filter (13) and transmit pause (14) take the written value on every write. Bit 14 drives `tx_pause_en`.
- R3: Writing 0 to test mode (7), monitor mode (5) or restricted mode (2) always clears that bit. Writing 1 sets it only if CCE (bit 1) and the readback INIT (bit 0) are both 1 before the write. Otherwise the bit keeps its value.
- R4: The retransmit-disable bit (6) changes only when CCE and readback INIT are both 1 before the write. Under any other condition a write leaves it unchanged.
- R5: CCE (bit 1) changes only when readback INIT is 1 before the write. `cfg_unlock` is high exactly when CCE and readback INIT are both 1.
- R6: The write rules use register values from before the write. A single write of 0x83 from the reset state gives 0x03, with test mode not set.
- R7: A write to INIT reaches `core_init` through a synchronizer. Bit 0 of the readback shows the value acknowledged back from the core, so it still shows the old value in the cycle after the write. `init_busy` is high from the cycle after the write until the readback matches.
- R8: A write to INIT while `init_busy` is high is ignored.
- R9: While clock-stop request (bit 4) is 1, INIT is set only once `tx_pending` is 0 and `bus_idle` is 1. While the bus is busy, INIT stays 0.
- R10: Clock-stop acknowledge (bit 3, also `clk_stop_ack`) rises only after readback INIT is 1 with the bus still quiet. Host writes to bit 3 have no effect.
- R11: Clearing the clock-stop request clears the acknowledge within two cycles, and INIT stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host register clock |
| rst | input | 1 | Synchronous active-high reset, host domain |
| core_clk | input | 1 | CAN core clock |
| core_rst | input | 1 | Synchronous active-high reset, core domain |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| tx_pending | input | 1 | Transmit requests still outstanding |
| bus_idle | input | 1 | CAN bus is idle |
| rd_data | output | 32 | Register readback |
| core_init | output | 1 | INIT as seen in the core domain |
| init_busy | output | 1 | INIT transfer between domains in progress |
| clk_stop_ack | output | 1 | CAN clocks may be gated |
| cfg_unlock | output | 1 | Protected configuration writes allowed |
| tx_pause_en | output | 1 | Transmit pause enable to the bit engine |

## Verification
A guard that reads the incoming data, or the pending INIT value instead of the acknowledged one, shows up on the next readback as a mode bit that was armed when it should not have been. The same goes for a retransmit-disable bit that moved while it was locked. A broken synchronizer or acknowledge path shows as a readback INIT that moves in the cycle right after the write, a busy flag that does not rise or never falls, or a mismatch between `core_init` and bit 0 once things have settled. A fault in the clock-stop ordering shows as INIT set while the bus is still busy, or as the acknowledge appearing before INIT reads 1. Both are visible within a few dozen host cycles of the quiet condition.

// File: rtl/can_ctrl_pkg.sv
package can_ctrl_pkg;

    localparam int REG_W = 32;

    localparam int P_INIT = 0;
    localparam int P_CCE  = 1;
    localparam int P_RSTR = 2;
    localparam int P_ACK  = 3;
    localparam int P_STOP = 4;
    localparam int P_MON  = 5;
    localparam int P_NRTX = 6;
    localparam int P_TST  = 7;
    localparam int P_FD   = 8;
    localparam int P_RSW  = 9;
    localparam int P_PXO  = 12;
    localparam int P_EFL  = 13;
    localparam int P_TXP  = 14;

    typedef struct packed {
        logic tx_pause;
        logic edge_filt;
        logic pxh_off;
        logic rate_sw;
        logic fd_on;
        logic test_mode;
        logic no_retx;
        logic monitor;
        logic stop_req;
        logic restricted;
        logic cfg_en;
    } mode_t;

    localparam mode_t MODE_RST = '0;

    // A 1 is accepted only while unlocked; a 0 always clears.
    function automatic logic guarded_set(logic cur, logic din, logic unlocked);
        return din & (unlocked | cur);
    endfunction

    function automatic mode_t next_mode(mode_t cur, logic init_rd,
                                        logic [REG_W-1:0] d);
        mode_t n;
        logic  unl;
        unl          = cur.cfg_en & init_rd;
        n            = cur;
        n.tx_pause   = d[P_TXP];
        n.edge_filt  = d[P_EFL];
        n.pxh_off    = d[P_PXO];
        n.rate_sw    = d[P_RSW];
        n.fd_on      = d[P_FD];
        n.stop_req   = d[P_STOP];
        n.test_mode  = guarded_set(cur.test_mode,  d[P_TST],  unl);
        n.monitor    = guarded_set(cur.monitor,    d[P_MON],  unl);
        n.restricted = guarded_set(cur.restricted, d[P_RSTR], unl);
        n.no_retx    = unl ? d[P_NRTX] : cur.no_retx;
        n.cfg_en     = init_rd ? d[P_CCE] : cur.cfg_en;
        return n;
    endfunction

    function automatic logic [REG_W-1:0] pack_rd(mode_t m, logic init_rd,
                                                 logic ack);
        logic [REG_W-1:0] r;
        r         = '0;
        r[P_INIT] = init_rd;
        r[P_CCE]  = m.cfg_en;
        r[P_RSTR] = m.restricted;
        r[P_ACK]  = ack;
        r[P_STOP] = m.stop_req;
        r[P_MON]  = m.monitor;
        r[P_NRTX] = m.no_retx;
        r[P_TST]  = m.test_mode;
        r[P_FD]   = m.fd_on;
        r[P_RSW]  = m.rate_sw;
        r[P_PXO]  = m.pxh_off;
        r[P_EFL]  = m.edge_filt;
        r[P_TXP]  = m.tx_pause;
        return r;
    endfunction

endpackage

// File: rtl/init_cdc.sv
module init_cdc #(
    parameter int STAGES = 2
) (
    input  logic h_clk,
    input  logic h_rst,
    input  logic c_clk,
    input  logic c_rst,
    input  logic req,
    output logic core_val,
    output logic ack
);
    logic [STAGES-1:0] c_sync;
    logic [STAGES-1:0] h_sync;

    generate
        if (STAGES > 1) begin : g_chain
            always_ff @(posedge c_clk) begin
                if (c_rst) c_sync <= '1;
                else       c_sync <= {c_sync[STAGES-2:0], req};
            end
            always_ff @(posedge h_clk) begin
                if (h_rst) h_sync <= '1;
                else       h_sync <= {h_sync[STAGES-2:0], core_val};
            end
        end else begin : g_single
            always_ff @(posedge c_clk) begin
                if (c_rst) c_sync <= '1;
                else       c_sync <= req;
            end
            always_ff @(posedge h_clk) begin
                if (h_rst) h_sync <= '1;
                else       h_sync <= core_val;
            end
        end
    endgenerate

    assign core_val = c_sync[STAGES-1];
    assign ack      = h_sync[STAGES-1];

    // Once acknowledged and request held, the returned value must not move.
    AST_ACK_SETTLED: assert property (@(posedge h_clk) disable iff (h_rst)
        (req == ack) && $stable(req) |=> $stable(ack)); // R7

endmodule

// File: rtl/ctrl_fields.sv
module ctrl_fields
    import can_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             init_rd,
    input  logic             init_busy,
    input  logic             stop_set,
    output mode_t            mode,
    output logic             init_req
);
    logic unlocked;
    assign unlocked = mode.cfg_en & init_rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode     <= MODE_RST;
            init_req <= 1'b1;
        end else begin
            if (wr_en) mode <= next_mode(mode, init_rd, wr_data);
            if (stop_set)
                init_req <= 1'b1;
            else if (wr_en && !init_busy)
                init_req <= wr_data[P_INIT];
        end
    end

    AST_TEST_GUARD: assert property (@(posedge clk) disable iff (rst)
        $rose(mode.test_mode) |-> $past(unlocked)); // R3
    AST_MON_GUARD: assert property (@(posedge clk) disable iff (rst)
        $rose(mode.monitor) |-> $past(unlocked)); // R3
    AST_RETX_GUARD: assert property (@(posedge clk) disable iff (rst)
        !$stable(mode.no_retx) |-> $past(unlocked)); // R4
    AST_CCE_GUARD: assert property (@(posedge clk) disable iff (rst)
        !$stable(mode.cfg_en) |-> $past(init_rd)); // R5
    AST_INIT_HOLD_BUSY: assert property (@(posedge clk) disable iff (rst)
        !$stable(init_req) |-> !$past(init_busy)); // R8

endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic stop_req,
    input  logic init_req,
    input  logic init_rd,
    input  logic init_busy,
    input  logic tx_pending,
    input  logic bus_idle,
    output logic stop_set,
    output logic ack
);
    logic quiet;
    assign quiet    = !tx_pending && bus_idle;
    assign stop_set = stop_req && quiet && !init_req && !init_busy;

    always_ff @(posedge clk) begin
        if (rst) ack <= 1'b0;
        else     ack <= stop_req && init_rd && !init_busy && (ack || quiet);
    end

    AST_ACK_AFTER_INIT: assert property (@(posedge clk) disable iff (rst)
        $rose(ack) |-> $past(init_rd)); // R10
    AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        ack |-> $past(stop_req)); // R11

endmodule

// File: rtl/can_ctrl_reg.sv
module can_ctrl_reg
    import can_ctrl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             core_clk,
    input  logic             core_rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             tx_pending,
    input  logic             bus_idle,
    output logic [REG_W-1:0] rd_data,
    output logic             core_init,
    output logic             init_busy,
    output logic             clk_stop_ack,
    output logic             cfg_unlock,
    output logic             tx_pause_en
);
    mode_t mode;
    logic  init_req;
    logic  init_ack;
    logic  stop_set;

    assign init_busy = init_req != init_ack;

    ctrl_fields u_fields (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .init_rd  (init_ack),
        .init_busy(init_busy),
        .stop_set (stop_set),
        .mode     (mode),
        .init_req (init_req)
    );

    clkstop_ctrl u_stop (
        .clk       (clk),
        .rst       (rst),
        .stop_req  (mode.stop_req),
        .init_req  (init_req),
        .init_rd   (init_ack),
        .init_busy (init_busy),
        .tx_pending(tx_pending),
        .bus_idle  (bus_idle),
        .stop_set  (stop_set),
        .ack       (clk_stop_ack)
    );

    init_cdc #(.STAGES(SYNC_STAGES)) u_cdc (
        .h_clk   (clk),
        .h_rst   (rst),
        .c_clk   (core_clk),
        .c_rst   (core_rst),
        .req     (init_req),
        .core_val(core_init),
        .ack     (init_ack)
    );

    assign rd_data     = pack_rd(mode, init_ack, clk_stop_ack);
    assign cfg_unlock  = mode.cfg_en & init_ack;
    assign tx_pause_en = mode.tx_pause;

endmodule

// File: tb/sim_can_ctrl_reg.sv
module sim_can_ctrl_reg;
    localparam int CLK_P  = 10;
    localparam int CCLK_P = 14;

    logic        clk = 1'b0, core_clk = 1'b0;
    logic        rst = 1'b1, core_rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        tx_pending = 1'b0, bus_idle = 1'b1;
    logic [31:0] rd_data;
    logic        core_init, init_busy, clk_stop_ack, cfg_unlock, tx_pause_en;

    always #(CLK_P/2)  clk = ~clk;
    always #(CCLK_P/2) core_clk = ~core_clk;

    can_ctrl_reg u0 (
        .clk(clk), .rst(rst), .core_clk(core_clk), .core_rst(core_rst),
        .wr_en(wr_en), .wr_data(wr_data), .tx_pending(tx_pending),
        .bus_idle(bus_idle), .rd_data(rd_data), .core_init(core_init),
        .init_busy(init_busy), .clk_stop_ack(clk_stop_ack),
        .cfg_unlock(cfg_unlock), .tx_pause_en(tx_pause_en)
    );

    typedef struct {
        logic [31:0] val;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    int n_chk  = 0;
    int n_fail = 0;

    task automatic check(input logic ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: compare readback when an expectation is queued.
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                sb_item_t it;
                it = sb_q.pop_front();
                check(rd_data == it.val, it.tag, rd_data, it.val);
            end
        end
    end

    task automatic expect_rd(input logic [31:0] v, input string tag);
        sb_item_t it;
        it.val = v;
        it.tag = tag;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
        while (init_busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_chk, n_fail);
    endtask

    initial begin
        #(CLK_P * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic seen_bad;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        core_rst = 1'b0;
        repeat (2) @(negedge clk);

        // R1 reset state
        expect_rd(32'h0000_0001, "R1 reset value");
        check(!init_busy && core_init, "R1 reset busy/core_init",
              {30'd0, init_busy, core_init}, 32'h1);

        // R3 R4 locked sets ignored (CCE=0)
        wr(32'h0000_00E5); settle();
        expect_rd(32'h0000_0001, "R3 R4 locked sets dropped");

        // R6 one write cannot unlock and arm test mode
        wr(32'h0000_0083); settle();
        expect_rd(32'h0000_0003, "R6 pre-write rule values");

        // R3 R4 R5 unlocked sets
        wr(32'h0000_00E7); settle();
        expect_rd(32'h0000_00E7, "R3 R4 unlocked sets");
        check(cfg_unlock, "R5 cfg_unlock high", {31'd0, cfg_unlock}, 32'h1);

        // R5 CCE cleared while INIT=1; guarded bits still held
        wr(32'h0000_00E5); settle();
        expect_rd(32'h0000_00E5, "R5 CCE clear");
        check(!cfg_unlock, "R5 cfg_unlock low", {31'd0, cfg_unlock}, 32'h0);

        // R3 clears always allowed, R4 locked retransmit bit kept
        wr(32'h0000_0001); settle();
        expect_rd(32'h0000_0041, "R3 clears allowed R4 kept");

        // R2 free fields, R10 bit 3 write ignored
        wr(32'h0000_7349); settle();
        expect_rd(32'h0000_7341, "R2 R10 free fields");
        check(tx_pause_en, "R2 tx_pause_en", {31'd0, tx_pause_en}, 32'h1);

        // R7 delayed INIT readback, R8 write during busy ignored
        wr(32'h0000_7340);
        check(init_busy, "R7 busy after write", {31'd0, init_busy}, 32'h1);
        check(rd_data[0] && core_init, "R7 readback lags",
              {30'd0, rd_data[0], core_init}, 32'h3);
        wr(32'h0000_7341);
        settle();
        expect_rd(32'h0000_7340, "R8 INIT write during busy ignored");
        check(!core_init, "R7 core_init cleared", {31'd0, core_init}, 32'h0);

        // R5 CCE locked while INIT=0
        wr(32'h0000_7342); settle();
        expect_rd(32'h0000_7340, "R5 CCE locked");

        // R1 reserved bits ignored
        wr(32'hFFFF_FF40); settle();
        expect_rd(32'h0000_7340, "R1 reserved bits");

        // R9 clock stop waits for a quiet bus
        tx_pending = 1'b1;
        bus_idle   = 1'b0;
        wr(32'h0000_7350);
        repeat (10) @(negedge clk);
        expect_rd(32'h0000_7350, "R9 pending tx holds INIT");
        tx_pending = 1'b0;
        repeat (10) @(negedge clk);
        expect_rd(32'h0000_7350, "R9 busy bus holds INIT");
        bus_idle = 1'b1;
        seen_bad = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (clk_stop_ack && !rd_data[0]) seen_bad = 1'b1;
        end
        check(!seen_bad, "R10 ack only after INIT", {31'd0, seen_bad}, 32'h0);
        expect_rd(32'h0000_7359, "R9 R10 stop sequence done");
        check(clk_stop_ack && core_init, "R10 clk_stop_ack",
              {30'd0, clk_stop_ack, core_init}, 32'h3);

        // R11 clearing the request drops the acknowledge
        wr(32'h0000_7341);
        repeat (2) @(negedge clk);
        expect_rd(32'h0000_7341, "R11 ack cleared INIT kept");
        check(!clk_stop_ack, "R11 clk_stop_ack low",
              {31'd0, clk_stop_ack}, 32'h0);

        summary();
        $finish;
    end
endmodule